// File: doc/BRIEF.md
# SONET Frame Aligner and Sync Detector

This block sits behind a deserializer that delivers one receive byte per clock. That byte has an arbitrary bit phase with respect to the line's true byte boundary. The block keeps a short history of incoming bytes and looks, at every one of the eight bit phases, for the framing sequence. The sequence is three A1 bytes (8'hF6) and then one A2 byte (8'h28), with bits taken MSB-first. When it finds the sequence, it locks that bit phase. From then on its output bytes are cut on the true byte boundary.

Alignment is first tentative, then confirmed, and is tracked by three named states.
- HUNT searches all phases.
- PRESYNC counts on-time repeats of the sequence at the locked phase.
- SYNC declares frame synchronization, raises the data-valid output and fires a fixed-length frame-sync pulse.

The transitions are as follows.
- HUNT to PRESYNC (lock): a sequence is found while the search enable is high.
- PRESYNC to PRESYNC (confirm): the sequence is seen again exactly one frame later.
- PRESYNC to SYNC (declare): the third on-time sequence is seen.
- PRESYNC to HUNT (reject): the predicted sequence is missing.
- SYNC to SYNC (track): the slot holds the sequence, or fewer than four consecutive slots have missed.
- SYNC to HUNT (loss): four consecutive predicted slots miss.

The frame length in bytes is a parameter, so short frames can be used in simulation. When the search enable is low, HUNT cannot lock, and the bit phase already held stays in place.

Top module: `frm_align`

## Requirements
- R1: While `search_en` is low, the block never leaves HUNT and never changes its bit phase. The phase found earlier, or 0 after reset, keeps shaping `dout`. Real framing sequences on the input are ignored.
- R2: A lock happens when the 32 bits 8'hF6, 8'hF6, 8'hF6, 8'h28 appear MSB-first in the input bit stream at any of the 8 bit phases. The phase at which they appear becomes the locked phase.
- R3: Input byte j is sampled at clock edge j. After edge j+2, `dout` holds the 8 stream bits that start p bits into input byte j, with the MSB first. Here p is the phase that was locked before edge j+2, and p is 0 before any lock.
- R4: `dout_valid` is low in HUNT and PRESYNC.
- R5: Take the first lock as detection 1. SYNC is entered on the edge after detection 3, where each detection falls exactly FRAME_BYTES bytes after the previous one. On that edge `dout_valid` rises, and `fsync_pulse` goes high for exactly 4 clock cycles.
- R6: In SYNC, a framing sequence anywhere other than the predicted slot causes no change to the phase, `dout_valid` or `fsync_pulse`.
- R7: In PRESYNC, a missing sequence at the predicted slot returns the block to HUNT. Three fresh on-time detections are then needed before SYNC.
- R8: In SYNC, four consecutive missed slots return the block to HUNT and drop `dout_valid` one edge after the fourth miss. A hit in the slot clears the miss count.
- R9: A synchronous active-low reset puts the block in HUNT with phase 0, `dout` = 0, and both `dout_valid` and `fsync_pulse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rst_n | input | 1 | Synchronous reset, active low |
| search_en | input | 1 | Arms the phase search in HUNT |
| din | input | 8 | Unaligned byte from the deserializer, first bit in the MSB |
| dout | output | 8 | Byte cut at the locked bit phase |
| dout_valid | output | 1 | High while frame synchronization holds |
| fsync_pulse | output | 1 | High for 4 cycles when sync is declared |

## Verification
The bench builds the block with FRAME_BYTES = 16. This makes a full HUNT to SYNC climb, a run of four missed slots and a resynchronization each take only a few dozen cycles.

With frames that short, the basic climb, including a payload look-alike in the first synchronized frame, is swept over all eight input bit phases.

Dedicated runs cover three more cases: a rejected PRESYNC, a loss of sync with a miss count that is cleared midway and then a relock, and an enable held low across real framing sequences. Every output is compared on every cycle with values the bench derives from frame positions.

// File: rtl/frm_pkg.sv
package frm_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_PRESYNC = 2'd1,
        ST_SYNC    = 2'd2
    } frm_state_e;

    localparam int          FRM_BITS     = 8;
    localparam logic [7:0]  FRM_A1       = 8'hF6;
    localparam logic [7:0]  FRM_A2       = 8'h28;
    localparam int          FRM_A1_RUN   = 3;
    localparam int          FRM_PAT_BYTES = FRM_A1_RUN + 1;

endpackage

// File: rtl/frm_window.sv
// Byte history register and bit-phase output selector.
module frm_window #(
    parameter int BYTE_W    = 8,
    parameter int PAT_BYTES = 4,
    localparam int HIST_W   = (PAT_BYTES + 1) * BYTE_W,
    localparam int OFF_W    = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] din,
    input  logic [OFF_W-1:0]  off,
    output logic [HIST_W-1:0] hist,
    output logic [BYTE_W-1:0] dout
);

    logic [HIST_W-1:0]   sr_q;
    logic [2*BYTE_W-1:0] pair;
    logic [2*BYTE_W-1:0] pair_sh;
    logic [BYTE_W-1:0]   sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
            dout <= '0;
        end else begin
            sr_q <= {sr_q[HIST_W-BYTE_W-1:0], din};
            dout <= sel;
        end
    end

    always_comb begin
        pair    = sr_q[2*BYTE_W-1:0];
        pair_sh = pair << off;
        sel     = pair_sh[2*BYTE_W-1 -: BYTE_W];
    end

    assign hist = sr_q;

endmodule

// File: rtl/frm_match.sv
// Framing sequence comparator at every bit phase, lowest phase preferred.
module frm_match #(
    parameter int BYTE_W    = 8,
    parameter int PAT_BYTES = 4,
    localparam int PAT_W    = PAT_BYTES * BYTE_W,
    localparam int WIN_W    = PAT_W + BYTE_W - 1,
    localparam int OFF_W    = $clog2(BYTE_W)
) (
    input  logic [WIN_W-1:0]  win,
    output logic [BYTE_W-1:0] hit_vec,
    output logic              hit_any,
    output logic [OFF_W-1:0]  hit_idx
);
    import frm_pkg::*;

    localparam logic [PAT_W-1:0] PATTERN = {{(PAT_BYTES-1){FRM_A1}}, FRM_A2};

    for (genvar k = 0; k < BYTE_W; k++) begin : g_phase
        assign hit_vec[k] = (win[WIN_W-1-k -: PAT_W] == PATTERN);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = OFF_W'(i);
        end
    end

    assign hit_any = |hit_vec;

endmodule

// File: rtl/frm_fsm.sv
// HUNT / PRESYNC / SYNC controller with frame slot counter.
module frm_fsm #(
    parameter int FRAME_BYTES  = 9720,
    parameter int SYNC_HITS    = 3,
    parameter int MISS_LIMIT   = 4,
    parameter int PULSE_CYCLES = 4,
    parameter int BYTE_W       = 8,
    localparam int OFF_W  = $clog2(BYTE_W),
    localparam int CNT_W  = $clog2(FRAME_BYTES),
    localparam int HIT_W  = $clog2(SYNC_HITS + 1),
    localparam int MISS_W = $clog2(MISS_LIMIT + 1),
    localparam int PUL_W  = $clog2(PULSE_CYCLES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               search_en,
    input  logic [BYTE_W-1:0]  hit_vec,
    input  logic               hit_any,
    input  logic [OFF_W-1:0]   hit_idx,
    output logic [OFF_W-1:0]   off,
    output frm_pkg::frm_state_e state,
    output logic               valid,
    output logic               fsync
);
    import frm_pkg::*;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BYTES - 1);

    frm_state_e        state_q, state_n;
    logic [OFF_W-1:0]  off_q, off_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [HIT_W-1:0]  hits_q, hits_n;
    logic [MISS_W-1:0] miss_q, miss_n;
    logic [PUL_W-1:0]  pulse_q, pulse_n;
    logic              at_slot;
    logic              slot_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            off_q   <= '0;
            cnt_q   <= '0;
            hits_q  <= '0;
            miss_q  <= '0;
            pulse_q <= '0;
        end else begin
            state_q <= state_n;
            off_q   <= off_n;
            cnt_q   <= cnt_n;
            hits_q  <= hits_n;
            miss_q  <= miss_n;
            pulse_q <= pulse_n;
        end
    end

    always_comb begin
        at_slot  = (cnt_q == LAST);
        slot_hit = hit_vec[off_q];
        state_n  = state_q;
        off_n    = off_q;
        hits_n   = hits_q;
        miss_n   = miss_q;
        cnt_n    = at_slot ? '0 : cnt_q + CNT_W'(1);
        pulse_n  = (pulse_q != '0) ? pulse_q - PUL_W'(1) : '0;
        unique case (state_q)
            ST_HUNT: begin
                if (search_en && hit_any) begin
                    state_n = ST_PRESYNC;
                    off_n   = hit_idx;
                    cnt_n   = '0;
                    hits_n  = HIT_W'(1);
                end
            end
            ST_PRESYNC: begin
                if (at_slot) begin
                    if (!slot_hit) begin
                        state_n = ST_HUNT;
                    end else if (hits_q == HIT_W'(SYNC_HITS - 1)) begin
                        state_n = ST_SYNC;
                        miss_n  = '0;
                        pulse_n = PUL_W'(PULSE_CYCLES);
                    end else begin
                        hits_n = hits_q + HIT_W'(1);
                    end
                end
            end
            ST_SYNC: begin
                if (at_slot) begin
                    if (slot_hit) begin
                        miss_n = '0;
                    end else if (miss_q == MISS_W'(MISS_LIMIT - 1)) begin
                        state_n = ST_HUNT;
                        miss_n  = '0;
                    end else begin
                        miss_n = miss_q + MISS_W'(1);
                    end
                end
            end
            default: state_n = ST_HUNT;
        endcase
    end

    always_comb begin
        valid = (state_q == ST_SYNC);
        fsync = (pulse_q != '0);
        off   = off_q;
        state = state_q;
    end

endmodule

// File: rtl/frm_align.sv
module frm_align #(
    parameter int FRAME_BYTES  = 9720,
    parameter int SYNC_HITS    = 3,
    parameter int MISS_LIMIT   = 4,
    parameter int PULSE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       search_en,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       dout_valid,
    output logic       fsync_pulse
);
    import frm_pkg::*;

    localparam int BYTE_W = FRM_BITS;
    localparam int PAT_B  = FRM_PAT_BYTES;
    localparam int HIST_W = (PAT_B + 1) * BYTE_W;
    localparam int OFF_W  = $clog2(BYTE_W);

    logic [HIST_W-1:0] hist;
    logic [BYTE_W-1:0] hit_vec;
    logic              hit_any;
    logic [OFF_W-1:0]  hit_idx;
    logic [OFF_W-1:0]  lock_off;
    frm_state_e        state;

    frm_window #(.BYTE_W(BYTE_W), .PAT_BYTES(PAT_B)) u_win (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (din),
        .off  (lock_off),
        .hist (hist),
        .dout (dout)
    );

    frm_match #(.BYTE_W(BYTE_W), .PAT_BYTES(PAT_B)) u_match (
        .win    (hist[HIST_W-1:1]),
        .hit_vec(hit_vec),
        .hit_any(hit_any),
        .hit_idx(hit_idx)
    );

    frm_fsm #(
        .FRAME_BYTES (FRAME_BYTES),
        .SYNC_HITS   (SYNC_HITS),
        .MISS_LIMIT  (MISS_LIMIT),
        .PULSE_CYCLES(PULSE_CYCLES),
        .BYTE_W      (BYTE_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .search_en(search_en),
        .hit_vec  (hit_vec),
        .hit_any  (hit_any),
        .hit_idx  (hit_idx),
        .off      (lock_off),
        .state    (state),
        .valid    (dout_valid),
        .fsync    (fsync_pulse)
    );

endmodule

// File: rtl/frm_align_chk.sv
module frm_align_chk #(
    parameter int PULSE_CYCLES = 4,
    localparam int RUN_W = $clog2(PULSE_CYCLES + 2) + 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                search_en,
    input logic                dout_valid,
    input logic                fsync_pulse,
    input logic [2:0]          lock_off,
    input frm_pkg::frm_state_e state
);
    import frm_pkg::*;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)           run_q <= '0;
        else if (fsync_pulse) run_q <= run_q + RUN_W'(1);
        else                  run_q <= '0;
    end

    p_pulse_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_pulse |-> (int'(run_q) < PULSE_CYCLES));

    p_pulse_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fsync_pulse) |-> (int'(run_q) == PULSE_CYCLES));

    p_valid_with_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_valid) |-> $rose(fsync_pulse));

    p_valid_from_presync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_valid) |-> ($past(state) == ST_PRESYNC));

    p_hold_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!search_en && state == ST_HUNT) |=> ($stable(lock_off) && state == ST_HUNT));

    p_no_realign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |=> $stable(lock_off));

endmodule

bind frm_align frm_align_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .search_en  (search_en),
    .dout_valid (dout_valid),
    .fsync_pulse(fsync_pulse),
    .lock_off   (lock_off),
    .state      (state)
);

// File: tb/frm_align_bench.sv
`timescale 1ns/1ps
module frm_align_bench;

    localparam int F = 16;
    localparam int NEVER = 1 << 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       search_en = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_valid;
    logic       fsync_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // scenario knobs
    int          sh;
    int          en_on, en_off;
    logic [15:0] bad_mask;
    int          look_fr;
    int          lock_p, sync1, loss_p, sync2;

    always #10 clk = ~clk;

    frm_align #(.FRAME_BYTES(F)) u_frm_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .search_en  (search_en),
        .din        (din),
        .dout       (dout),
        .dout_valid (dout_valid),
        .fsync_pulse(fsync_pulse)
    );

    // true byte n of the line, before the bit shift
    function automatic logic [7:0] tbyte(int n);
        int p, fr;
        if (n < 0) return 8'h00;
        p  = n % F;
        fr = n / F;
        if (fr == look_fr && p >= 8 && p <= 10) return 8'hF6;
        if (fr == look_fr && p == 11) return 8'h28;
        if (p < 3) return 8'hF6;
        if (p == 3) return (fr < 16 && bad_mask[fr]) ? 8'h29 : 8'h28;
        return 8'((n * 3 + 1) & 255);
    endfunction

    // input byte j: line bits delayed by sh zero bits
    function automatic logic [7:0] dbyte(int j);
        logic [15:0] w;
        w = {tbyte(j - 1), tbyte(j)};
        return 8'(w >> sh);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_case(input string tag, input int cycles);
        bit ev, ef;
        logic [7:0] ed;
        rst_n = 1'b0;
        search_en = 1'b0;
        din = 8'h00;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check(dout_valid == 1'b0, "R9 valid after reset", int'(dout_valid), 0);
        check(fsync_pulse == 1'b0, "R9 fsync after reset", int'(fsync_pulse), 0);
        check(dout == 8'h00, "R9 dout after reset", int'(dout), 0);
        rst_n = 1'b1;
        for (int j = 0; j < cycles; j++) begin
            din = dbyte(j);
            search_en = (j >= en_on && j < en_off);
            @(posedge clk);
            @(negedge clk);
            ev = (j >= sync1 && j < loss_p) || (sync2 >= 0 && j >= sync2);
            ef = (j >= sync1 && j < sync1 + 4) || (sync2 >= 0 && j >= sync2 && j < sync2 + 4);
            ed = (j > lock_p) ? tbyte(j - 2) : dbyte(j - 2);
            check(dout_valid == ev, {tag, " R4 R8 dout_valid"}, int'(dout_valid), int'(ev));
            check(fsync_pulse == ef, {tag, " R5 fsync_pulse"}, int'(fsync_pulse), int'(ef));
            check(dout == ed, {tag, " R2 R3 dout"}, int'(dout), int'(ed));
        end
    endtask

    initial begin
        // R2 R3 R5 R6: climb to sync at every bit phase; look-alike in frame 3 payload
        for (int s = 0; s < 8; s++) begin
            sh = s; en_on = 0; en_off = NEVER; bad_mask = 16'h0000; look_fr = 3;
            lock_p = 5; sync1 = 2*F + 5; loss_p = NEVER; sync2 = -1;
            run_case($sformatf("R6 phase%0d", s), 6*F + 4);
        end
        // R7: frame 1 marker corrupted, presync rejects, three fresh detections needed
        sh = 3; en_on = 0; en_off = NEVER; bad_mask = 16'h0002; look_fr = -1;
        lock_p = 5; sync1 = 4*F + 5; loss_p = NEVER; sync2 = -1;
        run_case("R7 presync reject", 7*F);
        // R8: misses in frames 3-5, hit in 6, misses 7-10 -> loss, relock to sync at 13
        sh = 5; en_on = 0; en_off = NEVER; bad_mask = 16'h07B8; look_fr = -1;
        lock_p = 5; sync1 = 2*F + 5; loss_p = 10*F + 5; sync2 = 13*F + 5;
        run_case("R8 loss and relock", 15*F);
        // R1: enable low through frames 0-2 (phase stays 0), on from frame 3,
        // off again in sync; after the loss the phase is kept and no relock occurs
        sh = 6; en_on = 3*F; en_off = 6*F; bad_mask = 16'h0780; look_fr = -1;
        lock_p = 3*F + 5; sync1 = 5*F + 5; loss_p = 10*F + 5; sync2 = -1;
        run_case("R1 enable hold", 15*F);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule